// File: doc/BRIEF.md
# Register Move and Accumulator ALU Unit

This unit executes single-byte opcodes from two bands of an 8-bit opcode space. It works over a small register file that holds six general registers and an accumulator. Opcodes of the form `01 ddd sss` copy one register into another. Opcodes of the form `10 ooo rrr` combine the accumulator with a register through one of eight arithmetic or logic operations. The unit keeps a carry flag and a zero flag, both updated by the arithmetic and logic band.

Each cycle the unit may accept one opcode, qualified by a valid strobe. Every result becomes visible on the clock edge that follows. The register code that would name a memory operand is not executed here. Any opcode that uses it raises a one-cycle indirect-access request for the surrounding logic and changes no state.

A debug port reads any register combinationally. The same port can also write a register while no opcode is being presented, so that the register file can be given starting values.

Top module: `rmau_top`

## Requirements
- R1: While `rst_n` is low, every register, both flags and `indirect_req` are zero. This is visible at the ports as `dbg_rdata` = 0 for every `dbg_sel` code, `carry_flag` = 0, `zero_flag` = 0 and `indirect_req` = 0.
- R2: A valid opcode 01 DDD SSS in which neither field is 110 copies register SSS into register DDD on the next clock edge, and leaves both flags unchanged. The register codes are: 000 B, 001 C, 010 D, 011 E, 100 H, 101 L, 110 memory operand, 111 A.
- R3: A valid opcode 10 OOO RRR with RRR not 110 and OOO in {000 add, 001 add with carry, 010 subtract, 011 subtract with borrow} writes the 8-bit result of A op RRR into A on the next edge.
- R4: Operation codes 100 (AND), 101 (XOR) and 110 (OR) write A op RRR into A and clear the carry flag.
- R5: Operation code 111 (compare) computes A minus RRR and sets both flags from it, but leaves A unchanged.
- R6: For add and add-with-carry, the carry flag is the carry out of bit 7. For subtract, subtract-with-borrow and compare, it is the borrow. The zero flag is set exactly when the 8-bit result is zero.
- R7: A valid opcode in the 0x40–0xBF bands whose source or destination code is 110 (this includes 0x76, 0x77, 0x7E and 0x86) raises `indirect_req` for exactly the one cycle after the edge. It modifies no register and no flag.
- R8: An opcode below 0x40 or above 0xBF, or any opcode presented while `op_valid` is low, changes no register and no flag and raises no request.
- R9: Reading debug code 110 always returns zero, and no write ever lands on code 110.
- R10: With `op_valid` low and `dbg_we` high, register `dbg_sel` takes `dbg_wdata` on the next edge. With `op_valid` high, the debug write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_valid | input | 1 | Opcode strobe |
| opcode | input | 8 | Opcode byte |
| dbg_sel | input | 3 | Register code for debug read or write |
| dbg_we | input | 1 | Debug write enable |
| dbg_wdata | input | DATA_W | Debug write data |
| dbg_rdata | output | DATA_W | Selected register contents |
| carry_flag | output | 1 | Carry or borrow flag |
| zero_flag | output | 1 | Zero-result flag |
| indirect_req | output | 1 | One-cycle memory-operand request |

## Verification
The checker assumes that `opcode` is stable and known whenever `op_valid` is high. It also assumes that reset is released away from a clock edge, so that the history it reads through `$past` starts from a clean reset cycle. The bench changes every input only on the falling clock edge. It holds `op_valid` for exactly one cycle per opcode and keeps `dbg_we` low while opcodes run, except in the one test that deliberately overlaps the two. Register starting values come only through the debug write port. After that, the bench walks a sequence of vectors whose expected values follow from the requirements.

// File: rtl/rmau_pkg.sv
package rmau_pkg;
  localparam int REG_W = 3;
  localparam int NREG = 1 << REG_W;
  localparam logic [REG_W-1:0] CODE_MEM = 3'b110;
  localparam logic [REG_W-1:0] CODE_ACC = 3'b111;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_ADC = 3'd1,
    ALU_SUB = 3'd2,
    ALU_SBC = 3'd3,
    ALU_AND = 3'd4,
    ALU_XOR = 3'd5,
    ALU_OR  = 3'd6,
    ALU_CMP = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_MOVE = 2'd1,
    CLS_ALU  = 2'd2,
    CLS_IND  = 2'd3
  } op_class_e;

  typedef struct packed {
    op_class_e       cls;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src;
    alu_op_e         alu;
  } dec_t;
endpackage

// File: rtl/rmau_decode.sv
module rmau_decode
  import rmau_pkg::*;
(
  input  logic       valid,
  input  logic [7:0] opcode,
  output dec_t       dec
);
  logic [REG_W-1:0] fld_hi;
  logic [REG_W-1:0] fld_lo;

  assign fld_hi = opcode[5:3];
  assign fld_lo = opcode[2:0];

  always_comb begin
    dec.cls = CLS_NONE;
    dec.dst = fld_hi;
    dec.src = fld_lo;
    dec.alu = alu_op_e'(fld_hi);
    if (valid) begin
      case (opcode[7:6])
        2'b01: begin
          if ((fld_hi == CODE_MEM) || (fld_lo == CODE_MEM)) dec.cls = CLS_IND;
          else                                              dec.cls = CLS_MOVE;
        end
        2'b10: begin
          dec.dst = CODE_ACC;
          if (fld_lo == CODE_MEM) dec.cls = CLS_IND;
          else                    dec.cls = CLS_ALU;
        end
        default: dec.cls = CLS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/rmau_alu.sv
module rmau_alu
  import rmau_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] res,
  output logic              carry,
  output logic              zero,
  output logic              wr_acc
);
  localparam int EXT_W = DATA_W + 1;

  logic [EXT_W-1:0] ax;
  logic [EXT_W-1:0] bx;
  logic [EXT_W-1:0] cx;
  logic [EXT_W-1:0] ext;

  assign ax = {1'b0, a};
  assign bx = {1'b0, b};
  assign cx = {{DATA_W{1'b0}}, cin};

  always_comb begin
    case (op)
      ALU_ADD: ext = ax + bx;
      ALU_ADC: ext = ax + bx + cx;
      ALU_SUB: ext = ax - bx;
      ALU_SBC: ext = ax - bx - cx;
      ALU_AND: ext = {1'b0, a & b};
      ALU_XOR: ext = {1'b0, a ^ b};
      ALU_OR:  ext = {1'b0, a | b};
      default: ext = ax - bx;
    endcase
  end

  assign res    = ext[DATA_W-1:0];
  assign carry  = ext[DATA_W];
  assign zero   = (res == '0);
  assign wr_acc = (op != ALU_CMP);
endmodule

// File: rtl/rmau_regfile.sv
module rmau_regfile
  import rmau_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [REG_W-1:0]  src_addr,
  input  logic [REG_W-1:0]  dbg_addr,
  output logic [DATA_W-1:0] src_data,
  output logic [DATA_W-1:0] acc_data,
  output logic [DATA_W-1:0] dbg_data
);
  logic [DATA_W-1:0] store_q [NREG];
  logic [DATA_W-1:0] store_d [NREG];

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      store_d[i] = store_q[i];
      if (REG_W'(i) == CODE_MEM) store_d[i] = '0;
      else if (we && (waddr == REG_W'(i))) store_d[i] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) store_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) store_q[i] <= store_d[i];
    end
  end

  assign src_data = store_q[src_addr];
  assign acc_data = store_q[CODE_ACC];
  assign dbg_data = store_q[dbg_addr];
endmodule

// File: rtl/rmau_top.sv
module rmau_top
  import rmau_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [7:0]        opcode,
  input  logic [2:0]        dbg_sel,
  input  logic              dbg_we,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic              carry_flag,
  output logic              zero_flag,
  output logic              indirect_req
);
  dec_t              dec;
  logic [DATA_W-1:0] src_val;
  logic [DATA_W-1:0] acc_val;
  logic [DATA_W-1:0] alu_res;
  logic              alu_c;
  logic              alu_z;
  logic              alu_wr;

  logic              rf_we;
  logic [REG_W-1:0]  rf_waddr;
  logic [DATA_W-1:0] rf_wdata;

  logic              carry_d;
  logic              zero_d;
  logic              ind_d;

  rmau_decode u_dec (
    .valid  (op_valid),
    .opcode (opcode),
    .dec    (dec)
  );

  rmau_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (rf_we),
    .waddr    (rf_waddr),
    .wdata    (rf_wdata),
    .src_addr (dec.src),
    .dbg_addr (dbg_sel),
    .src_data (src_val),
    .acc_data (acc_val),
    .dbg_data (dbg_rdata)
  );

  rmau_alu #(.DATA_W(DATA_W)) u_alu (
    .a      (acc_val),
    .b      (src_val),
    .cin    (carry_flag),
    .op     (dec.alu),
    .res    (alu_res),
    .carry  (alu_c),
    .zero   (alu_z),
    .wr_acc (alu_wr)
  );

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = dec.dst;
    rf_wdata = src_val;
    carry_d  = carry_flag;
    zero_d   = zero_flag;
    ind_d    = 1'b0;
    case (dec.cls)
      CLS_MOVE: rf_we = 1'b1;
      CLS_ALU: begin
        rf_we    = alu_wr;
        rf_waddr = CODE_ACC;
        rf_wdata = alu_res;
        carry_d  = alu_c;
        zero_d   = alu_z;
      end
      CLS_IND: ind_d = 1'b1;
      default: begin
        if (!op_valid && dbg_we && (dbg_sel != CODE_MEM)) begin
          rf_we    = 1'b1;
          rf_waddr = dbg_sel;
          rf_wdata = dbg_wdata;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_flag   <= 1'b0;
      zero_flag    <= 1'b0;
      indirect_req <= 1'b0;
    end else begin
      carry_flag   <= carry_d;
      zero_flag    <= zero_d;
      indirect_req <= ind_d;
    end
  end
endmodule

// File: rtl/rmau_checker.sv
module rmau_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [7:0] opcode,
  input logic       carry_flag,
  input logic       zero_flag,
  input logic       indirect_req,
  input logic       rf_we,
  input logic [2:0] rf_waddr
);
  a_r7_req_needs_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    indirect_req |-> $past(op_valid));

  a_r7_req_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    indirect_req |-> ($stable(carry_flag) && $stable(zero_flag)));

  a_r8_idle_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(op_valid) |-> ($stable(carry_flag) && $stable(zero_flag) && !indirect_req));

  a_r8_outside_band_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_valid && ((opcode[7:6] == 2'b00) || (opcode[7:6] == 2'b11)))
    |-> ($stable(carry_flag) && $stable(zero_flag) && !indirect_req));

  a_r2_move_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_valid && (opcode[7:6] == 2'b01)) |-> ($stable(carry_flag) && $stable(zero_flag)));

  a_r4_logic_clears_carry: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_valid && (opcode[7:6] == 2'b10) && (opcode[2:0] != 3'b110) &&
          ((opcode[5:3] == 3'b100) || (opcode[5:3] == 3'b101) || (opcode[5:3] == 3'b110)))
    |-> !carry_flag);

  a_r9_no_mem_slot_write: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr != 3'b110));
endmodule

bind rmau_top rmau_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid     (op_valid),
  .opcode       (opcode),
  .carry_flag   (carry_flag),
  .zero_flag    (zero_flag),
  .indirect_req (indirect_req),
  .rf_we        (rf_we),
  .rf_waddr     (rf_waddr)
);

// File: tb/tb_rmau_top.sv
`timescale 1ns/1ps
module tb_rmau_top;
  logic       clk;
  logic       rst_n;
  logic       op_valid;
  logic [7:0] opcode;
  logic [2:0] dbg_sel;
  logic       dbg_we;
  logic [7:0] dbg_wdata;
  logic [7:0] dbg_rdata;
  logic       carry_flag;
  logic       zero_flag;
  logic       indirect_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  rmau_top dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .dbg_sel(dbg_sel), .dbg_we(dbg_we), .dbg_wdata(dbg_wdata),
    .dbg_rdata(dbg_rdata), .carry_flag(carry_flag), .zero_flag(zero_flag),
    .indirect_req(indirect_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {opcode, register read, expected value, carry, zero, request}
  localparam int NVEC = 26;
  localparam logic [21:0] VEC [NVEC] = '{
    {8'h41, 3'd0, 8'h34, 1'b0, 1'b0, 1'b0},  // R2 B<-C
    {8'h7C, 3'd7, 8'h80, 1'b0, 1'b0, 1'b0},  // R2 A<-H
    {8'h80, 3'd7, 8'hB4, 1'b0, 1'b0, 1'b0},  // R3 add
    {8'h84, 3'd7, 8'h34, 1'b1, 1'b0, 1'b0},  // R6 add carry out
    {8'h89, 3'd7, 8'h69, 1'b0, 1'b0, 1'b0},  // R3 add with carry
    {8'h92, 3'd7, 8'h79, 1'b1, 1'b0, 1'b0},  // R6 subtract borrow
    {8'h9B, 3'd7, 8'h69, 1'b0, 1'b0, 1'b0},  // R3 subtract with borrow
    {8'hA3, 3'd7, 8'h09, 1'b0, 1'b0, 1'b0},  // R4 and
    {8'hAF, 3'd7, 8'h00, 1'b0, 1'b1, 1'b0},  // R4 xor, R6 zero
    {8'hB5, 3'd7, 8'h01, 1'b0, 1'b0, 1'b0},  // R4 or
    {8'hBD, 3'd7, 8'h01, 1'b0, 1'b1, 1'b0},  // R5 compare equal
    {8'hBA, 3'd7, 8'h01, 1'b1, 1'b0, 1'b0},  // R5 compare borrow
    {8'h9F, 3'd7, 8'hFF, 1'b1, 1'b0, 1'b0},  // R3 sbc self with borrow in
    {8'h8F, 3'd7, 8'hFF, 1'b1, 1'b0, 1'b0},  // R3 adc self with carry in
    {8'h87, 3'd7, 8'hFE, 1'b1, 1'b0, 1'b0},  // R6 add self
    {8'h76, 3'd7, 8'hFE, 1'b1, 1'b0, 1'b1},  // R7 reserved load code
    {8'h77, 3'd7, 8'hFE, 1'b1, 1'b0, 1'b1},  // R7 store through memory code
    {8'h7E, 3'd7, 8'hFE, 1'b1, 1'b0, 1'b1},  // R7 load from memory code
    {8'h86, 3'd7, 8'hFE, 1'b1, 1'b0, 1'b1},  // R7 alu memory operand
    {8'h00, 3'd7, 8'hFE, 1'b1, 1'b0, 1'b0},  // R8 below band
    {8'hC3, 3'd7, 8'hFE, 1'b1, 1'b0, 1'b0},  // R8 above band
    {8'h3E, 3'd7, 8'hFE, 1'b1, 1'b0, 1'b0},  // R8 below band
    {8'h57, 3'd2, 8'hFE, 1'b1, 1'b0, 1'b0},  // R2 D<-A
    {8'h6A, 3'd5, 8'hFE, 1'b1, 1'b0, 1'b0},  // R2 L<-D
    {8'h95, 3'd7, 8'h00, 1'b0, 1'b1, 1'b0},  // R6 subtract to zero
    {8'h80, 3'd7, 8'h34, 1'b0, 1'b0, 1'b0}   // R3 add after zero
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic dbg_write(input logic [2:0] sel, input logic [7:0] val);
    @(negedge clk);
    dbg_we = 1'b1; dbg_sel = sel; dbg_wdata = val; op_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic read_reg(input logic [2:0] sel, input logic [7:0] exp, input string req);
    dbg_sel = sel;
    #0.5;
    check(req, dbg_rdata, exp);
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; opcode = 8'h00;
    dbg_sel = 3'd0; dbg_we = 1'b0; dbg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int r = 0; r < 8; r++) read_reg(3'(r), 8'h00, "R1 register");
    check("R1 carry", carry_flag, 0);
    check("R1 zero", zero_flag, 0);
    check("R1 request", indirect_req, 0);

    // R10 preload through debug port
    dbg_write(3'd0, 8'h12); dbg_write(3'd1, 8'h34); dbg_write(3'd2, 8'hF0);
    dbg_write(3'd3, 8'h0F); dbg_write(3'd4, 8'h80); dbg_write(3'd5, 8'h01);
    dbg_write(3'd7, 8'h7F);
    read_reg(3'd2, 8'hF0, "R10 debug write");
    read_reg(3'd7, 8'h7F, "R10 debug write");

    for (int i = 0; i < NVEC; i++) begin
      logic [21:0] v;
      v = VEC[i];
      @(negedge clk);
      opcode = v[21:14]; dbg_sel = v[13:11]; op_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      op_valid = 1'b0;
      #0.5;
      check($sformatf("R2/R3/R4/R5/R7 value vec %0d", i), dbg_rdata, v[10:3]);
      check($sformatf("R6 carry vec %0d", i), carry_flag, v[2]);
      check($sformatf("R6 zero vec %0d", i), zero_flag, v[1]);
      check($sformatf("R7 request vec %0d", i), indirect_req, v[0]);
    end

    // R8 opcode without strobe
    @(negedge clk);
    opcode = 8'h80; op_valid = 1'b0; dbg_sel = 3'd7;
    @(posedge clk);
    @(negedge clk);
    #0.5;
    check("R8 no strobe value", dbg_rdata, 8'h34);
    check("R8 no strobe request", indirect_req, 0);

    // R10 debug write ignored while an opcode is presented
    @(negedge clk);
    opcode = 8'h00; op_valid = 1'b1; dbg_we = 1'b1; dbg_sel = 3'd7; dbg_wdata = 8'h55;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; dbg_we = 1'b0;
    read_reg(3'd7, 8'h34, "R10 overlapped write ignored");

    // R9 memory code never stores
    dbg_write(3'd6, 8'hA5);
    read_reg(3'd6, 8'h00, "R9 memory code read");

    // R1 reset in mid run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    read_reg(3'd7, 8'h00, "R1 mid-run reset A");
    read_reg(3'd0, 8'h00, "R1 mid-run reset B");
    check("R1 mid-run carry", carry_flag, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule